// File: doc/BRIEF.md
# Serial Rule Program Loader

This block takes a stream of bytes from a serial receiver and loads a set of packet-filter rules into the program memories of a group of processing cores. The stream opens with a header. The header is parsed into a small table that records each rule's start address and instruction count. Downstream logic reads that table through an index port.

The header is followed by the instruction bytes. The block packs every eight bytes into one 64-bit instruction and places it on a single program bus that all cores share. A write stays on that bus until every core has acknowledged it. When the last instruction has been taken, a loaded flag tells the rule scheduler that the cores can run.

A reload input discards all progress, including a write that is still waiting on the bus. It then makes the parser wait for a fresh header, so a new rule set can be installed while the rest of the system keeps running.

Top module: `rule_stream_loader`

## Requirements
- R1: After reset, `pw_valid`, `rules_loaded`, `range_err` and `md_count` are all zero and `byte_rdy` is one.
- R2: The first accepted byte of a set is the rule count and appears on `md_count`. It is followed by four bytes per rule: start address low byte, start address high byte, length low byte, length high byte. Rules with index below MAX_RULES can be read on `md_start`/`md_len` by setting `md_idx`.
- R3: After the header, every eight accepted bytes form one instruction, with the first byte in bits 7:0. Each instruction is issued as one bus write. Write addresses run 0, 1, 2 and so on. The number of writes equals the sum of all declared lengths.
- R4: A write keeps `pw_valid`, `pw_addr` and `pw_data` steady until each bit of `core_ack` has been seen high at least once during that write. Acknowledges may arrive in different cycles. `pw_valid` falls in the cycle after the last missing acknowledge.
- R5: `byte_rdy` is low while a write is pending. A byte offered while `byte_rdy` is low is not consumed.
- R6: `rules_loaded` rises in the same cycle that the final write drops. If the total declared length is zero, it rises right after the last header byte, or right after the count byte when the count is zero.
- R7: Once `rules_loaded` is high, further bytes cause no writes and leave the table and `md_count` unchanged.
- R8: `range_err` becomes set and stays set when any rule has start plus length greater than PMEM_DEPTH, or when the count exceeds MAX_RULES. In the second case the extra entries are consumed but not stored. Loading continues either way.
- R9: A `new_rules` pulse clears `rules_loaded`, `range_err`, `pw_valid` and `md_count` in the next cycle and abandons any pending write. It drops a byte offered in the same cycle, and the next accepted byte is read as a rule count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_rules | input | 1 | Restart loading with a fresh rule set |
| byte_vld | input | 1 | Incoming stream byte is valid |
| byte_dat | input | 8 | Incoming stream byte |
| byte_rdy | output | 1 | Block can take a byte this cycle |
| pw_valid | output | 1 | Program bus write pending |
| pw_addr | output | AW | Program bus write address |
| pw_data | output | 64 | Program bus instruction word |
| core_ack | input | NCORES | Per-core write acknowledge |
| md_idx | input | IW | Rule table read index |
| md_start | output | 16 | Start address of indexed rule |
| md_len | output | 16 | Length of indexed rule |
| md_count | output | 8 | Rule count of current set |
| rules_loaded | output | 1 | All rules stored in every core |
| range_err | output | 1 | Sticky rule range error |

## Verification
A reload request can land in the same cycle as a pending bus write that still lacks acknowledges, and also in the same cycle as an offered stream byte. The bench provokes this by holding all acknowledges back. It then pulses `new_rules` together with a byte whose value, if it were taken, would become a wrong rule count. It judges the result by checking that the write disappears in the next cycle, and that a following well-formed set reports its own count and its own writes starting from address zero. Acknowledge timing is randomised per core, and each cycle of every write is checked for steadiness and for a release exactly one cycle after the last acknowledge.

// File: rtl/rule_stream_loader.sv
module rule_stream_loader #(
  parameter int NCORES     = 4,
  parameter int MAX_RULES  = 4,
  parameter int PMEM_DEPTH = 256,
  parameter int AW         = 16,
  localparam int IW = (MAX_RULES > 1) ? $clog2(MAX_RULES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_rules,
  input  logic              byte_vld,
  input  logic [7:0]        byte_dat,
  output logic              byte_rdy,
  output logic              pw_valid,
  output logic [AW-1:0]     pw_addr,
  output logic [63:0]       pw_data,
  input  logic [NCORES-1:0] core_ack,
  input  logic [IW-1:0]     md_idx,
  output logic [15:0]       md_start,
  output logic [15:0]       md_len,
  output logic [7:0]        md_count,
  output logic              rules_loaded,
  output logic              range_err
);

  localparam logic [8:0]  MR9   = 9'(MAX_RULES);
  localparam logic [16:0] DEP17 = 17'(PMEM_DEPTH);

  typedef enum logic [1:0] {ST_CNT, ST_META, ST_INSN, ST_DONE} st_t;

  st_t               st;
  logic [7:0]        rule_i;
  logic [1:0]        fld;
  logic [15:0]       start_r;
  logic [7:0]        len_lo;
  logic [2:0]        bi;
  logic [55:0]       sh;
  logic [23:0]       remain;
  logic [NCORES-1:0] seen;
  logic [15:0]       tbl_start [MAX_RULES];
  logic [15:0]       tbl_len   [MAX_RULES];

  assign byte_rdy = !pw_valid;
  assign md_start = tbl_start[md_idx];
  assign md_len   = tbl_len[md_idx];

  wire              take      = byte_vld && byte_rdy && !new_rules;
  wire [NCORES-1:0] got       = seen | core_ack;
  wire              wr_done   = pw_valid && (&got);
  wire [15:0]       len_w     = {byte_dat, len_lo};
  wire [16:0]       end_w     = {1'b0, start_r} + {1'b0, len_w};
  wire              last_rule = (rule_i == md_count - 8'd1);
  wire [23:0]       remain_n  = remain + {8'd0, len_w};
  wire              store_ok  = {1'b0, rule_i} < MR9;

  always_ff @(posedge clk) begin
    if (!rst_n || new_rules) begin
      st           <= ST_CNT;
      rule_i       <= '0;
      fld          <= '0;
      bi           <= '0;
      remain       <= '0;
      seen         <= '0;
      pw_valid     <= 1'b0;
      pw_addr      <= '0;
      md_count     <= '0;
      rules_loaded <= 1'b0;
      range_err    <= 1'b0;
      if (!rst_n) begin
        start_r <= '0;
        len_lo  <= '0;
        sh      <= '0;
        pw_data <= '0;
        for (int i = 0; i < MAX_RULES; i++) begin
          tbl_start[i] <= '0;
          tbl_len[i]   <= '0;
        end
      end
    end else begin
      if (pw_valid) seen <= wr_done ? '0 : got;
      if (wr_done) begin
        pw_valid <= 1'b0;
        pw_addr  <= pw_addr + 1'b1;
        remain   <= remain - 24'd1;
        if (remain == 24'd1) begin
          st           <= ST_DONE;
          rules_loaded <= 1'b1;
        end
      end
      if (take) begin
        case (st)
          ST_CNT: begin
            md_count <= byte_dat;
            rule_i   <= '0;
            fld      <= '0;
            remain   <= '0;
            pw_addr  <= '0;
            if (byte_dat == 8'd0) begin
              st           <= ST_DONE;
              rules_loaded <= 1'b1;
            end else begin
              st <= ST_META;
            end
          end
          ST_META: begin
            fld <= fld + 2'd1;
            case (fld)
              2'd0: start_r[7:0]  <= byte_dat;
              2'd1: start_r[15:8] <= byte_dat;
              2'd2: len_lo        <= byte_dat;
              default: begin
                if (store_ok) begin
                  tbl_start[rule_i[IW-1:0]] <= start_r;
                  tbl_len[rule_i[IW-1:0]]   <= len_w;
                end
                if (!store_ok || end_w > DEP17) range_err <= 1'b1;
                remain <= remain_n;
                rule_i <= rule_i + 8'd1;
                if (last_rule) begin
                  bi <= '0;
                  if (remain_n == 24'd0) begin
                    st           <= ST_DONE;
                    rules_loaded <= 1'b1;
                  end else begin
                    st <= ST_INSN;
                  end
                end
              end
            endcase
          end
          ST_INSN: begin
            bi <= bi + 3'd1;
            if (bi == 3'd7) begin
              pw_valid <= 1'b1;
              pw_data  <= {byte_dat, sh};
            end else begin
              sh <= {byte_dat, sh[55:8]};
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  hold_until_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid && !(&(seen | core_ack)) && !new_rules
      |=> pw_valid && $stable(pw_addr) && $stable(pw_data));

  // R4
  release_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid && (&(seen | core_ack)) && !new_rules |=> !pw_valid);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pw_valid) && !$past(new_rules) |-> pw_addr == $past(pw_addr) + 1'b1);

  // R6
  loaded_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rules_loaded |-> !pw_valid);

  // R7
  done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rules_loaded && !new_rules |=> rules_loaded && $stable(md_count));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err && !new_rules |=> range_err);

  // R9
  reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_rules |=> !rules_loaded && !range_err && !pw_valid && md_count == 8'd0);

endmodule

// File: tb/tb_rule_stream_loader.sv
module tb_rule_stream_loader;
  localparam int NC = 4;
  localparam int MR = 4;
  localparam int DEPTH = 256;

  logic clk = 0, rst_n = 0, new_rules = 0, byte_vld = 0;
  logic [7:0] byte_dat = 0;
  logic byte_rdy, pw_valid, rules_loaded, range_err;
  logic [15:0] pw_addr, md_start, md_len;
  logic [63:0] pw_data;
  logic [NC-1:0] core_ack = '0;
  logic [1:0] md_idx = '0;
  logic [7:0] md_count;

  rule_stream_loader #(.NCORES(NC), .MAX_RULES(MR), .PMEM_DEPTH(DEPTH), .AW(16)) dut (
    .clk(clk), .rst_n(rst_n), .new_rules(new_rules), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .byte_rdy(byte_rdy), .pw_valid(pw_valid), .pw_addr(pw_addr), .pw_data(pw_data),
    .core_ack(core_ack), .md_idx(md_idx), .md_start(md_start), .md_len(md_len),
    .md_count(md_count), .rules_loaded(rules_loaded), .range_err(range_err));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit ended = 0;
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // ack responder
  bit ack_en = 1, abort = 0, prv = 0, all_acked = 0;
  int cyc, maxd;
  int dly [NC];
  int nwr = 0;
  logic [15:0] wlog_a [256];
  logic [63:0] wlog_d [256];
  logic [15:0] ha;
  logic [63:0] hd;

  always @(negedge clk) begin
    core_ack = '0;
    if (pw_valid && !prv) begin
      if (nwr < 256) begin wlog_a[nwr] = pw_addr; wlog_d[nwr] = pw_data; end
      nwr++;
      ha = pw_addr; hd = pw_data; cyc = 0; maxd = 0; all_acked = 0;
      for (int i = 0; i < NC; i++) begin
        dly[i] = int'($urandom_range(4, 1));
        if (dly[i] > maxd) maxd = dly[i];
      end
    end else if (pw_valid && prv) begin
      chk(pw_addr == ha && pw_data == hd, "R4 hold", {48'd0, pw_addr}, {48'd0, ha});
      chk(!all_acked, "R4 release", 64'(pw_valid), 64'd0);
    end else if (!pw_valid && prv && !abort) begin
      chk(all_acked, "R4 early drop", 64'(all_acked), 64'd1);
    end
    if (pw_valid && ack_en && !all_acked) begin
      cyc++;
      for (int i = 0; i < NC; i++) core_ack[i] = (dly[i] == cyc);
      if (cyc >= maxd) all_acked = 1;
    end
    prv = pw_valid;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    wrap_up();
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!byte_rdy) @(negedge clk);
    byte_vld = 1; byte_dat = b;
    @(negedge clk);
    byte_vld = 0;
  endtask

  logic [15:0] st_a [8];
  logic [15:0] ln_a [8];
  logic [63:0] words [64];

  function automatic bit exp_err(input int n);
    bit e = (n > MR);
    for (int i = 0; i < n; i++)
      if (32'(st_a[i]) + 32'(ln_a[i]) > DEPTH) e = 1;
    return e;
  endfunction

  function automatic int exp_total(input int n);
    int t = 0;
    for (int i = 0; i < n; i++) t += int'(ln_a[i]);
    return t;
  endfunction

  task automatic reload();
    @(negedge clk); new_rules = 1;
    @(negedge clk); new_rules = 0;
    chk(!rules_loaded && md_count == 0 && !range_err, "R9 reload", {rules_loaded, md_count}, 0);
  endtask

  task automatic run_set(input int n, input bit stall);
    int tot = exp_total(n);
    int guard;
    for (int k = 0; k < tot; k++) words[k] = {$urandom, $urandom};
    nwr = 0;
    if (n == 0) begin
      chk(!rules_loaded, "R6 before", 64'(rules_loaded), 0);
      send_byte(8'd0);
      chk(rules_loaded, "R6 zero count", 64'(rules_loaded), 1);
    end else begin
      send_byte(8'(n));
      for (int i = 0; i < n; i++) begin
        send_byte(st_a[i][7:0]); send_byte(st_a[i][15:8]); send_byte(ln_a[i][7:0]);
        if (i == n - 1 && tot == 0) chk(!rules_loaded, "R6 before", 64'(rules_loaded), 0);
        send_byte(ln_a[i][15:8]);
      end
      if (tot == 0) chk(rules_loaded, "R6 zero length", 64'(rules_loaded), 1);
      for (int k = 0; k < tot; k++) begin
        if (stall && k == 1) begin
          for (int c = 0; c < 5; c++) begin
            byte_vld = 1; byte_dat = 8'hA5;
            @(negedge clk);
            chk(!byte_rdy && pw_valid, "R5 stall", {byte_rdy, pw_valid}, 64'd1);
          end
          byte_vld = 0; ack_en = 1;
        end
        for (int b = 0; b < 8; b++) send_byte(words[k][8*b +: 8]);
      end
      guard = 0;
      while ((nwr < tot || pw_valid) && guard < 200) begin @(negedge clk); guard++; end
      chk(rules_loaded, "R6 loaded", 64'(rules_loaded), 1);
    end
    chk(nwr == tot, "R3 write count", 64'(nwr), 64'(tot));
    for (int k = 0; k < tot && k < 64; k++) begin
      chk(wlog_a[k] == 16'(k), "R3 address", {48'd0, wlog_a[k]}, 64'(k));
      chk(wlog_d[k] == words[k], "R3 data", wlog_d[k], words[k]);
    end
    chk(md_count == 8'(n), "R2 count", 64'(md_count), 64'(n));
    for (int i = 0; i < n && i < MR; i++) begin
      md_idx = 2'(i); #1;
      chk(md_start == st_a[i] && md_len == ln_a[i], "R2 table", {md_start, md_len}, {st_a[i], ln_a[i]});
    end
    chk(range_err == exp_err(n), "R8 range", 64'(range_err), 64'(exp_err(n)));
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(!pw_valid && !rules_loaded && !range_err && md_count == 0 && byte_rdy, "R1 reset",
        {pw_valid, rules_loaded, range_err, md_count, byte_rdy}, 64'd1);
    rst_n = 1;
    @(negedge clk);

    // directed set
    st_a[0] = 0; ln_a[0] = 2; st_a[1] = 2; ln_a[1] = 3; st_a[2] = 5; ln_a[2] = 1;
    run_set(3, 0);

    // R7: trailing bytes ignored
    nwr = 0;
    for (int i = 0; i < 10; i++) send_byte(8'($urandom));
    repeat (3) @(negedge clk);
    md_idx = 0; #1;
    chk(nwr == 0 && md_count == 3 && rules_loaded && md_len == 2, "R7 ignored",
        {nwr[7:0], md_count, md_len}, {8'd0, 8'd3, 16'd2});

    // random sets, some with stall
    for (int it = 0; it < 4; it++) begin
      int n = int'($urandom_range(4, 1));
      reload();
      for (int i = 0; i < n; i++) begin
        st_a[i] = 16'($urandom_range(200, 0)); ln_a[i] = 16'($urandom_range(4, 1));
      end
      if (it[0]) begin ack_en = 0; ln_a[0] = 2; end
      run_set(n, it[0]);
    end

    // R8 boundary: exactly fits, then one over
    reload();
    st_a[0] = 252; ln_a[0] = 4; run_set(1, 0);
    reload();
    st_a[0] = 1; ln_a[0] = 1; st_a[1] = 254; ln_a[1] = 3; run_set(2, 0);
    // R8 too many rules
    reload();
    for (int i = 0; i < 5; i++) begin st_a[i] = 16'(i * 8); ln_a[i] = 1; end
    run_set(5, 0);
    // R8 sticky across reload clears
    reload();
    st_a[0] = 0; ln_a[0] = 0; run_set(1, 0);
    reload();
    run_set(0, 0);

    // R9 same cycle: reload with pending write and offered byte
    reload();
    ack_en = 0;
    send_byte(8'd1); send_byte(0); send_byte(0); send_byte(8'd2); send_byte(0);
    for (int b = 0; b < 8; b++) send_byte(8'(b));
    @(negedge clk);
    chk(pw_valid, "R4 pending", 64'(pw_valid), 1);
    abort = 1;
    new_rules = 1; byte_vld = 1; byte_dat = 8'd7;
    @(negedge clk);
    new_rules = 0; byte_vld = 0;
    chk(!pw_valid && !rules_loaded && md_count == 0 && byte_rdy, "R9 abort",
        {pw_valid, rules_loaded, md_count, byte_rdy}, 64'd1);
    repeat (2) @(negedge clk);
    abort = 0; ack_en = 1;
    st_a[0] = 10; ln_a[0] = 2; st_a[1] = 20; ln_a[1] = 1;
    run_set(2, 0);

    repeat (4) @(negedge clk);
    wrap_up();
  end
endmodule